// File: doc/BRIEF.md
# Tiered Round-Robin Slave-Port Arbiter

This block decides which of eight bus masters may own one slave port of a multi-channel crossbar. Every master holds a two-bit urgency level, zero being the least urgent and three the most. A bank of sixteen programmable words, one per slave port, stores these levels. A parameter chooses the word this instance reads. When the port is free, the block finds the most urgent level among the requesting masters and picks one master from that level only.

Inside each level a separate rotating pointer remembers the master served last at that level. The next grant goes to the first requester after it, so a master gives up its turn after each completed bus cycle. A grant stays on its master for as long as that master keeps its cycle request high. Once the request drops the port is idle for one clock, and arbitration runs again on that idle clock.

Software rewrites the level words through a small write port and reads a word back through a combinational read port.

Top module: `prio_rr_arbiter`

## Requirements
- R1: After reset the grant is all zero, every level word reads zero, and every level's pointer names master 0 as last served, so the first grant at any level searches from master 1 upward.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` into word `cfg_addr_i` at the next rising edge. `cfg_rdata_o` always shows word `cfg_addr_i`. Master m's level sits in bits [2m+1:2m] of a word.
- R3: The grant is one-hot or all zero. It stays zero while no master requests and the port is idle.
- R4: When the grant is zero and at least one master requests, the next edge grants one requesting master whose level is the highest level among the requesters.
- R5: Among requesters at the winning level, the grant goes to the first one found when stepping upward from that level's last-served master, wrapping from 7 to 0.
- R6: While the owning master keeps its request high, the grant holds unchanged whatever the other requests or level writes do.
- R7: When the owner's request is low at an edge, the grant clears at that edge. That level's pointer becomes the owner, the other levels' pointers stay unchanged, and at least one clock with zero grant follows.
- R8: A level write made while a grant is held has no effect on that grant and is used at the next arbitration.
- R9: Only the word selected by the slave-index parameter (default 0) affects arbitration. Writes to other words change only what they read back.
- R10: With master 0 at level 3 and masters 1 to 4 at level 1, master 0 wins every arbitration in which it requests. Without master 0, forty back-to-back grants split ten to each of masters 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 8 | Bus-cycle request, one bit per master |
| gnt_o | output | 8 | One-hot grant, registered |
| cfg_we_i | input | 1 | Level word write enable |
| cfg_addr_i | input | 4 | Level word index for write and read |
| cfg_wdata_i | input | 16 | Level word write data |
| cfg_rdata_o | output | 16 | Level word at `cfg_addr_i` |

## Verification
Two events can fall on the same clock: a level write to the active word, and either a grant release or a new arbitration. The directed part writes the active word while a grant is held and then drops the owner's request. It expects the winner to follow the new levels only from the arbitration after the release. The random part issues writes to any word, including the active one, on arbitrary cycles while requests change. A bench model applies each write after that cycle's arbitration, and every cycle's grant is compared with it.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic {
    PORT_FREE = 1'b0,
    PORT_HELD = 1'b1
  } port_state_e;
endpackage

// File: rtl/prio_word_bank.sv
module prio_word_bank #(
  parameter int unsigned N_WORDS  = 16,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SEL_WORD = 0,
  localparam int unsigned AW      = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] active_word
);
  logic [N_WORDS-1:0][WORD_W-1:0] bank_q;
  logic [N_WORDS-1:0]             word_en;

  // per-word clock enable
  for (genvar w = 0; w < N_WORDS; w++) begin : g_dec
    assign word_en[w] = wr_en && (wr_addr == AW'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      for (int w = 0; w < N_WORDS; w++) begin
        if (word_en[w]) bank_q[w] <= wr_data;
      end
    end
  end

  assign rd_data     = bank_q[rd_addr];
  assign active_word = bank_q[SEL_WORD];
endmodule

// File: rtl/level_scan.sv
module level_scan #(
  parameter int unsigned N_M      = 8,
  parameter int unsigned N_LEVELS = 4,
  localparam int unsigned LVL_W   = $clog2(N_LEVELS),
  localparam int unsigned WORD_W  = N_M * LVL_W
) (
  input  logic [N_M-1:0]                req,
  input  logic [WORD_W-1:0]             levels,
  output logic [N_LEVELS-1:0][N_M-1:0]  lvl_req,
  output logic [LVL_W-1:0]              top_lvl,
  output logic                          any_req
);
  always_comb begin
    lvl_req = '0;
    for (int m = 0; m < N_M; m++) begin
      if (req[m]) lvl_req[levels[m*LVL_W +: LVL_W]][m] = 1'b1;
    end
  end

  // highest populated level wins; later iterations override earlier ones
  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (|lvl_req[l]) top_lvl = LVL_W'(l);
    end
  end

  assign any_req = |req;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N_M = 8,
  localparam int unsigned IW = $clog2(N_M)
) (
  input  logic [N_M-1:0] cand,
  input  logic [IW-1:0]  last_idx,
  output logic [N_M-1:0] pick_oh,
  output logic [IW-1:0]  pick_idx
);
  always_comb begin
    logic found;
    found    = 1'b0;
    pick_oh  = '0;
    pick_idx = '0;
    for (int k = 1; k <= N_M; k++) begin
      int c;
      c = (int'(last_idx) + k) % N_M;
      if (!found && cand[c]) begin
        found      = 1'b1;
        pick_oh[c] = 1'b1;
        pick_idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
  import prio_arb_pkg::*;
#(
  parameter int unsigned N_M      = 8,
  parameter int unsigned N_LEVELS = 4,
  localparam int unsigned IW      = $clog2(N_M),
  localparam int unsigned LVL_W   = $clog2(N_LEVELS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_M-1:0]                req,
  input  logic                          any_req,
  input  logic [N_M-1:0]                win_oh,
  input  logic [IW-1:0]                 win_idx,
  input  logic [LVL_W-1:0]              win_lvl,
  output logic [N_M-1:0]                gnt,
  output logic [N_LEVELS-1:0][IW-1:0]   last_served
);
  port_state_e               state_q, state_d;
  logic [N_M-1:0]            gnt_q, gnt_d;
  logic [IW-1:0]             own_q, own_d;
  logic [LVL_W-1:0]          olvl_q, olvl_d;
  logic [N_LEVELS-1:0]       ptr_en;
  logic [N_LEVELS-1:0][IW-1:0] ptr_q;

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    own_d   = own_q;
    olvl_d  = olvl_q;
    ptr_en  = '0;
    unique case (state_q)
      PORT_FREE: begin
        if (any_req) begin
          state_d = PORT_HELD;
          gnt_d   = win_oh;
          own_d   = win_idx;
          olvl_d  = win_lvl;
        end
      end
      PORT_HELD: begin
        if (!req[own_q]) begin
          state_d        = PORT_FREE;
          gnt_d          = '0;
          ptr_en[olvl_q] = 1'b1;
        end
      end
      default: state_d = PORT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PORT_FREE;
      gnt_q   <= '0;
      own_q   <= '0;
      olvl_q  <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      own_q   <= own_d;
      olvl_q  <= olvl_d;
    end
  end

  for (genvar l = 0; l < N_LEVELS; l++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q[l] <= '0;
      else if (ptr_en[l]) ptr_q[l] <= own_q;
    end
  end

  assign gnt         = gnt_q;
  assign last_served = ptr_q;
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter #(
  parameter int unsigned N_M       = 8,
  parameter int unsigned N_LEVELS  = 4,
  parameter int unsigned N_SLAVES  = 16,
  parameter int unsigned SLAVE_IDX = 0,
  localparam int unsigned LVL_W    = $clog2(N_LEVELS),
  localparam int unsigned WORD_W   = N_M * LVL_W,
  localparam int unsigned AW       = $clog2(N_SLAVES),
  localparam int unsigned IW       = $clog2(N_M)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_M-1:0]    req_i,
  output logic [N_M-1:0]    gnt_o,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o
);
  logic [WORD_W-1:0]              act_word;
  logic [N_LEVELS-1:0][N_M-1:0]   lvl_req;
  logic [LVL_W-1:0]               top_lvl;
  logic                           any_req;
  logic [N_LEVELS-1:0][IW-1:0]    last_served;
  logic [N_LEVELS-1:0][N_M-1:0]   lvl_pick;
  logic [N_LEVELS-1:0][IW-1:0]    lvl_pick_idx;

  prio_word_bank #(.N_WORDS(N_SLAVES), .WORD_W(WORD_W), .SEL_WORD(SLAVE_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we_i), .wr_addr(cfg_addr_i), .wr_data(cfg_wdata_i),
    .rd_addr(cfg_addr_i), .rd_data(cfg_rdata_o), .active_word(act_word)
  );

  level_scan #(.N_M(N_M), .N_LEVELS(N_LEVELS)) u_scan (
    .req(req_i), .levels(act_word),
    .lvl_req(lvl_req), .top_lvl(top_lvl), .any_req(any_req)
  );

  // one rotating picker per urgency level
  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    rr_pick #(.N_M(N_M)) u_pick (
      .cand(lvl_req[l]), .last_idx(last_served[l]),
      .pick_oh(lvl_pick[l]), .pick_idx(lvl_pick_idx[l])
    );
  end

  grant_ctrl #(.N_M(N_M), .N_LEVELS(N_LEVELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req_i), .any_req(any_req),
    .win_oh(lvl_pick[top_lvl]), .win_idx(lvl_pick_idx[top_lvl]), .win_lvl(top_lvl),
    .gnt(gnt_o), .last_served(last_served)
  );
endmodule

// File: rtl/prio_arb_chk.sv
module prio_arb_chk #(
  parameter int unsigned N_M = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N_M-1:0] req,
  input logic [N_M-1:0] gnt
);
  assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_idle_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> (gnt == '0));

  assert_grant_to_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req != '0) |=> ((gnt & $past(req)) != '0));

  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & req) != '0) |=> (gnt == $past(gnt)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));
endmodule

bind prio_rr_arbiter prio_arb_chk #(.N_M(N_M)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_i), .gnt(gnt_o)
);

// File: tb/tb_prio_rr_arbiter.sv
module tb_prio_rr_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req;
  logic [7:0]  gnt;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [15:0] mregs [16];
  int          mptr [4];
  logic [7:0]  mgnt;
  int          mown, mlvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_rr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(int m);
    return int'((mregs[0] >> (2*m)) & 16'h3);
  endfunction

  // one clock: model next state from current inputs, advance, compare
  task automatic step();
    logic [7:0]  ng = mgnt;
    int          nown = mown, nlvl = mlvl;
    logic        wr = cfg_we;
    logic [3:0]  wa = cfg_addr;
    logic [15:0] wd = cfg_wdata;
    if (mgnt != 8'h00) begin
      if ((mgnt & req) == 8'h00) begin
        ng = 8'h00;
        mptr[mlvl] = mown;
      end
    end else if (req != 8'h00) begin
      int top = 0;
      bit found = 0;
      for (int m = 0; m < 8; m++) if (req[m] && lvl_of(m) > top) top = lvl_of(m);
      for (int k = 1; k <= 8; k++) begin
        int c = (mptr[top] + k) % 8;
        if (!found && req[c] && lvl_of(c) == top) begin
          found = 1; ng = 8'h01 << c; nown = c; nlvl = top;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    mgnt = ng; mown = nown; mlvl = nlvl;
    if (wr) mregs[wa] = wd;
    chk("R3/R4/R5/R6/R7 model grant", {8'h00, gnt}, {8'h00, mgnt});
  endtask

  task automatic wr_word(logic [3:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt [8];
    int hold;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    mgnt = '0; mown = 0; mlvl = 0;
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    for (int i = 0; i < 4; i++) mptr[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 grant after reset", {8'h00, gnt}, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      cfg_addr = 4'(i); #1;
      chk("R1 word zero after reset", cfg_rdata, 16'h0000);
    end
    rst_n = 1'b1;
    step();
    chk("R3 idle without requests", {8'h00, gnt}, 16'h0000);

    // R1: all masters at level 0, pointer starts after master 0
    req = 8'hFF; step();
    chk("R1 first grant master 1", {8'h00, gnt}, 16'h0002);
    req = 8'h00; step(); step();

    // R2: write / read back
    wr_word(4'd5, 16'hA5C3);
    cfg_addr = 4'd5; #1;
    chk("R2 readback word 5", cfg_rdata, 16'hA5C3);

    // R9: other slave word ignored
    wr_word(4'd3, 16'hFFFF);
    req = 8'h81; step();
    chk("R9 other word ignored, level-0 rotation", {8'h00, gnt}, 16'h0080);

    // R8: write during held grant; R6 hold
    wr_word(4'd0, 16'h000C);
    chk("R6 grant held across write", {8'h00, gnt}, 16'h0080);
    req = 8'h03; step();
    chk("R7 release clears grant", {8'h00, gnt}, 16'h0000);
    step();
    chk("R8 new level used at next arbitration", {8'h00, gnt}, 16'h0002);
    req = 8'h00; step(); step();

    // R10: master 0 at level 3, masters 1..4 at level 1
    wr_word(4'd0, 16'h0157);
    req = 8'h1F; step();
    chk("R10 master 0 wins", {8'h00, gnt}, 16'h0001);
    req = 8'h1E; step();
    chk("R7 release after master 0", {8'h00, gnt}, 16'h0000);
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    hold = 0;
    for (int cyc = 0; cyc < 400 && (cnt[1]+cnt[2]+cnt[3]+cnt[4]) < 40; cyc++) begin
      req = 8'h1E;
      if (gnt != 8'h00) begin
        if (hold == 0) for (int m = 0; m < 8; m++) if (gnt[m]) cnt[m]++;
        hold++;
        if (hold >= 2) begin req = 8'h1E & ~gnt; hold = 0; end
      end
      step();
    end
    for (int m = 1; m <= 4; m++) chk("R10 even rotation", 16'(cnt[m]), 16'd10);
    req = 8'h00; step(); step();

    // random mix
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int m = 0; m < 8; m++) req[m] = (($urandom % 100) < (mgnt[m] ? 85 : 35));
      cfg_we = (($urandom % 10) == 0);
      cfg_addr = (($urandom % 2) == 0) ? 4'd0 : 4'($urandom);
      cfg_wdata = 16'($urandom);
      step();
    end
    cfg_we = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule